// File: doc/BRIEF.md
# Eight-Line Prioritised Interrupt Controller

This block collects interrupt requests from eight peripheral lines, ranks them by fixed priority and signals the processor when one of them needs service. Each line is edge sensitive. A rising edge on a line sets a pending bit, unless that line is masked. When the processor acknowledges, the block returns an 8-bit vector made of a programmable base plus the line number. The granted line then moves from the pending set to the in-service set. It stays in service until software sends an end-of-interrupt command.

Software reaches the block through a byte-wide port with two addresses. Address 0 takes command bytes. The block decodes an initialisation start, end-of-interrupt commands and a readback selector from the bit pattern of each byte. Reading address 0 returns either the pending register or the in-service register. Address 1 carries the interrupt mask. After an initialisation start, address 1 instead takes the vector base and then a mode byte.

Top module: `irq_ctrl8`

## Requirements
- R1: After reset `cpu_irq` is low, the pending, in-service and mask registers are all zero, readback on address 0 shows the pending register, and the vector base is zero.
- R2: A line sets its pending bit only on a low-to-high transition. A line held high is counted once, and it does not set the bit again after that bit has been acknowledged.
- R3: A rising edge on a line whose mask bit is 1 is dropped. Clearing the mask bit later does not bring the request back. A pending bit whose mask bit is 1 is never presented.
- R4: `cpu_irq` is high when an unmasked pending bit exists and no in-service bit blocks it. Line 0 has the highest priority, and the presented line is the lowest-numbered unmasked pending bit.
- R5: An in-service bit at an index less than or equal to the lowest unmasked pending index holds `cpu_irq` low.
- R6: When `cpu_ack` is high during a cycle in which line i is presented, in-service bit i is set and pending bit i is cleared at that clock edge. While line i is presented, `vec_out` equals the vector base plus i. An acknowledge given while `cpu_irq` is low has no effect.
- R7: Writing address 0 with bit 4 set starts initialisation. The next write to address 1 stores the written byte with its low three bits forced to 0 as the vector base. The write after that, to address 1, is the mode byte and returns the port to normal operation. Neither of these two writes changes the mask.
- R8: Outside initialisation, a write to address 1 loads the mask register. A read of address 1 always returns the mask.
- R9: A write to address 0 with bits 4:3 = 00 and bits 7:5 = 001 clears the lowest-numbered set in-service bit.
- R10: A write to address 0 with bits 4:3 = 00 and bits 7:5 = 011 clears the in-service bit numbered by bits 2:0. Any other code in bits 7:5 with bits 4:3 = 00 leaves the in-service register unchanged.
- R11: A write to address 0 with bit 7 = 0 and bits 4:3 = 01 sets the readback on address 0: low bits 10 select the pending register and low bits 11 select the in-service register. Low bits 00 or 01 keep the current selection.
- R12: If a new rising edge on a line and an acknowledge of that same line happen in one cycle, the pending bit ends up set.
- R13: Once an end-of-interrupt removes a blocking in-service bit, a request that is still pending is presented again without any new edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_addr | input | 1 | Register address: 0 for command/status, 1 for mask/data |
| bus_wr | input | 1 | Write strobe, one byte per cycle while high |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the register selected by `bus_addr`, combinational |
| irq_lines | input | 8 | Interrupt request lines, rising-edge sensitive |
| cpu_irq | output | 1 | Interrupt request to the processor |
| cpu_ack | input | 1 | Processor acknowledge of the presented line |
| vec_out | output | 8 | Vector of the presented line (base plus line number) |

## Verification
The assertions assume that software follows the programming rules. Every initialisation-start byte has 0x3 in its low nibble, and the mode byte that ends the sequence is always 0x01. The end-of-interrupt assertion also assumes that no acknowledge arrives in the same cycle. The random stimulus builds command bytes only from legal patterns. It looks at the bench's own model of the initialisation state, so that it sends a base and then exactly 0x01 at the right times. The end-of-interrupt check is guarded so that it does not fire when an acknowledge falls in the same cycle.

// File: rtl/irqc_pkg.sv
// Shared constants and types for the eight-line interrupt controller.
// Assumes one line per bit of the byte-wide register port.
package irqc_pkg;
    localparam int unsigned IRQC_LINES = 8;
    localparam int unsigned IRQC_DATA_W = 8;

    // Progress through the initialisation byte sequence.
    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_BASE = 2'd1,
        SEQ_MODE = 2'd2
    } irqc_seq_t;

    // Register shown on reads of address 0.
    typedef enum logic {
        RD_PEND = 1'b0,
        RD_SVC  = 1'b1
    } irqc_rdsel_t;
endpackage

// File: rtl/irqc_req_capture.sv
// Pending-request register with rising-edge capture.
// Each line is compared against its value one cycle earlier. A line already
// high during reset is not an edge. A new edge wins over a clear on the same bit.
module irqc_req_capture #(
    parameter int unsigned N = irqc_pkg::IRQC_LINES
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] lines,
    input  logic [N-1:0] mask,
    input  logic [N-1:0] clr,
    output logic [N-1:0] pend_q
);
    logic [N-1:0] prev_q;
    logic [N-1:0] rise;

    // Remember each line's previous level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '1;
        else        prev_q <= lines;
    end

    // Unmasked rising edges only.
    always_comb rise = lines & ~prev_q & ~mask;

    // Per-bit pending state: set by an edge, cleared by an acknowledge.
    for (genvar g = 0; g < N; g++) begin : g_bit
        always_ff @(posedge clk) begin
            if (!rst_n)      pend_q[g] <= 1'b0;
            else if (rise[g]) pend_q[g] <= 1'b1;
            else if (clr[g])  pend_q[g] <= 1'b0;
        end
    end
endmodule

// File: rtl/irqc_cfg.sv
// Register-port decoder: initialisation sequencer, mask, vector base,
// readback selection and end-of-interrupt command pulses.
// Assumes at most one write per cycle; the command byte is classified
// from its bit pattern: bit 4 (init), bits 4:3 = 00 (EOI), bit7=0 & 4:3=01 (select).
module irqc_cfg
    import irqc_pkg::*;
#(
    parameter int unsigned W = IRQC_DATA_W,
    localparam int unsigned IDX_W = $clog2(W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic             addr,
    input  logic [W-1:0]     wdata,
    output logic [W-1:0]     mask_q,
    output logic [W-1:0]     base_q,
    output irqc_rdsel_t      rdsel_q,
    output irqc_seq_t        seq_q,
    output logic             eoi_low,
    output logic             eoi_idx_hit,
    output logic [IDX_W-1:0] eoi_idx
);
    logic cmd_wr, data_wr;
    logic is_init, is_eoi, is_sel;

    // Classify the write.
    always_comb begin
        cmd_wr      = wr && !addr;
        data_wr     = wr && addr;
        is_init     = wdata[4];
        is_eoi      = (wdata[4:3] == 2'b00);
        is_sel      = !wdata[7] && (wdata[4:3] == 2'b01);
        eoi_low     = cmd_wr && is_eoi && (wdata[7:5] == 3'b001);
        eoi_idx_hit = cmd_wr && is_eoi && (wdata[7:5] == 3'b011);
        eoi_idx     = wdata[IDX_W-1:0];
    end

    // Sequencer: init start, then base byte, then mode byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q <= SEQ_IDLE;
        end else if (cmd_wr && is_init) begin
            seq_q <= SEQ_BASE;
        end else if (data_wr) begin
            case (seq_q)
                SEQ_BASE: seq_q <= SEQ_MODE;
                SEQ_MODE: seq_q <= SEQ_IDLE;
                default:  seq_q <= SEQ_IDLE;
            endcase
        end
    end

    // Vector base, low bits forced to zero so base plus line never carries.
    always_ff @(posedge clk) begin
        if (!rst_n)                              base_q <= '0;
        else if (data_wr && seq_q == SEQ_BASE)   base_q <= {wdata[W-1:IDX_W], {IDX_W{1'b0}}};
    end

    // Mask loads only when no init sequence is in progress.
    always_ff @(posedge clk) begin
        if (!rst_n)                              mask_q <= '0;
        else if (data_wr && seq_q == SEQ_IDLE)   mask_q <= wdata;
    end

    // Readback selection; low bits 1x choose, 0x keep.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rdsel_q <= RD_PEND;
        else if (cmd_wr && !is_init && is_sel && wdata[1])
            rdsel_q <= wdata[0] ? RD_SVC : RD_PEND;
    end
endmodule

// File: rtl/irqc_resolve.sv
// Fixed-priority resolver. Scans from line 0 upward; an in-service bit met
// before any unmasked pending bit blocks the request. Purely combinational.
module irqc_resolve #(
    parameter int unsigned N = irqc_pkg::IRQC_LINES,
    localparam int unsigned IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     pend,
    input  logic [N-1:0]     svc,
    input  logic [N-1:0]     mask,
    output logic             valid,
    output logic [IDX_W-1:0] idx
);
    // Priority scan with an early-stop flag.
    always_comb begin
        logic stop;
        stop  = 1'b0;
        valid = 1'b0;
        idx   = '0;
        for (int i = 0; i < N; i++) begin
            if (!stop) begin
                if (svc[i]) begin
                    stop = 1'b1;
                end else if (pend[i] && !mask[i]) begin
                    stop  = 1'b1;
                    valid = 1'b1;
                    idx   = IDX_W'(i);
                end
            end
        end
    end
endmodule

// File: rtl/irq_ctrl8.sv
// Eight-line edge-triggered interrupt controller, single device.
// Holds the in-service register and ties together capture, configuration
// and priority resolution. Assumes the processor acknowledges only while
// cpu_irq is high; a stray acknowledge is ignored.
module irq_ctrl8
    import irqc_pkg::*;
#(
    parameter int unsigned N = IRQC_LINES,
    localparam int unsigned IDX_W = $clog2(N)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         bus_addr,
    input  logic         bus_wr,
    input  logic [N-1:0] bus_wdata,
    output logic [N-1:0] bus_rdata,
    input  logic [N-1:0] irq_lines,
    output logic         cpu_irq,
    input  logic         cpu_ack,
    output logic [N-1:0] vec_out
);
    logic [N-1:0]     irr_q, isr_q, mask_q, base_q;
    irqc_rdsel_t      rdsel_q;
    irqc_seq_t        seq_q;
    logic             eoi_low, eoi_idx_hit;
    logic [IDX_W-1:0] eoi_idx;
    logic             win_valid;
    logic [IDX_W-1:0] win_idx;
    logic [N-1:0]     grant, svc_clr;

    irqc_cfg #(.W(N)) u_cfg (
        .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
        .mask_q(mask_q), .base_q(base_q), .rdsel_q(rdsel_q), .seq_q(seq_q),
        .eoi_low(eoi_low), .eoi_idx_hit(eoi_idx_hit), .eoi_idx(eoi_idx)
    );

    irqc_req_capture #(.N(N)) u_req (
        .clk(clk), .rst_n(rst_n), .lines(irq_lines), .mask(mask_q),
        .clr(grant), .pend_q(irr_q)
    );

    irqc_resolve #(.N(N)) u_res (
        .pend(irr_q), .svc(isr_q), .mask(mask_q), .valid(win_valid), .idx(win_idx)
    );

    // Acknowledge one-hot, only when a line is being presented.
    always_comb grant = (cpu_ack && win_valid) ? (N'(1) << win_idx) : '0;

    // End-of-interrupt clear vector: lowest set bit, or an indexed bit.
    always_comb begin
        svc_clr = '0;
        if (eoi_low)     svc_clr = isr_q & (~isr_q + N'(1));
        if (eoi_idx_hit) svc_clr = N'(1) << eoi_idx;
    end

    // In-service register: acknowledge sets, end-of-interrupt clears.
    always_ff @(posedge clk) begin
        if (!rst_n) isr_q <= '0;
        else        isr_q <= (isr_q & ~svc_clr) | grant;
    end

    // Outputs towards the processor and the register port.
    always_comb begin
        cpu_irq   = win_valid;
        vec_out   = base_q + N'(win_idx);
        bus_rdata = bus_addr ? mask_q : ((rdsel_q == RD_SVC) ? isr_q : irr_q);
    end
endmodule

// File: rtl/irqc_checker.sv
// Property checker for irq_ctrl8, attached by bind. Observes ports and
// the register state of the top level.
module irqc_checker
    import irqc_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       bus_addr,
    input logic       bus_wr,
    input logic [7:0] bus_wdata,
    input logic       cpu_irq,
    input logic       cpu_ack,
    input logic [7:0] vec_out,
    input logic [7:0] irq_lines,
    input logic [7:0] irr_q,
    input logic [7:0] isr_q,
    input logic [7:0] mask_q,
    input irqc_seq_t  seq_q
);
    // Bits strictly below index i.
    function automatic logic [7:0] below(input logic [2:0] i);
        logic [7:0] m;
        for (int k = 0; k < 8; k++) m[k] = (k < int'(i));
        return m;
    endfunction

    // Bits at or below index i.
    function automatic logic [7:0] upto(input logic [2:0] i);
        logic [7:0] m;
        for (int k = 0; k < 8; k++) m[k] = (k <= int'(i));
        return m;
    endfunction

    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (irr_q == 8'h00 && isr_q == 8'h00 && mask_q == 8'h00 && seq_q == SEQ_IDLE));

    a_r3_new_bits_need_unmasked_line: assert property (@(posedge clk) disable iff (!rst_n)
        ((irr_q & ~$past(irr_q)) & ~($past(irq_lines) & ~$past(mask_q))) == 8'h00);

    a_r4_presented_is_pending: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_irq |-> (irr_q[vec_out[2:0]] && !mask_q[vec_out[2:0]]));

    a_r4_lowest_first: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_irq |-> ((irr_q & ~mask_q & below(vec_out[2:0])) == 8'h00));

    a_r5_service_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_irq |-> ((isr_q & upto(vec_out[2:0])) == 8'h00));

    a_r6_ack_enters_service: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_ack && cpu_irq) |=> isr_q[$past(vec_out[2:0])]);

    a_r7_init_word_format: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !bus_addr && bus_wdata[4]) |-> (bus_wdata[3:0] == 4'h3));

    a_r7_mode_word_value: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr && seq_q == SEQ_MODE) |-> (bus_wdata == 8'h01));

    a_r8_mask_load: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr && seq_q == SEQ_IDLE) |=> (mask_q == $past(bus_wdata)));

    a_r9_nonspecific_eoi: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !bus_addr && bus_wdata[7:3] == 5'b00100 && !(cpu_ack && cpu_irq))
        |=> ($countones(isr_q) == $countones($past(isr_q)) - (($past(isr_q) != 8'h00) ? 1 : 0)));
endmodule

bind irq_ctrl8 irqc_checker u_chk (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .cpu_irq(cpu_irq), .cpu_ack(cpu_ack),
    .vec_out(vec_out), .irq_lines(irq_lines), .irr_q(irr_q), .isr_q(isr_q),
    .mask_q(mask_q), .seq_q(seq_q)
);

// File: tb/irq_ctrl8_bench.sv
// Bench for irq_ctrl8: directed corner cases, then seeded random traffic,
// every cycle compared against a model built from the requirements.
module irq_ctrl8_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_addr = 1'b0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic [7:0] irq_lines = 8'h00;
    logic       cpu_irq;
    logic       cpu_ack = 1'b0;
    logic [7:0] vec_out;

    int n_chk = 0;
    int n_fail = 0;
    int cycles = 0;
    string tag = "R1";

    // Model state.
    logic [7:0] m_irr, m_isr, m_mask, m_base, m_prev;
    logic [1:0] m_seq;     // 0 idle, 1 expect base, 2 expect mode
    logic       m_svc_sel; // 0 pending readback, 1 in-service readback

    always #10 clk = ~clk;

    irq_ctrl8 u_irq_ctrl8 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_lines(irq_lines),
        .cpu_irq(cpu_irq), .cpu_ack(cpu_ack), .vec_out(vec_out)
    );

    // {valid, index} of the line that should be presented (R4, R5).
    function automatic logic [3:0] present(input logic [7:0] p, input logic [7:0] s,
                                           input logic [7:0] m);
        for (int i = 0; i < 8; i++) begin
            if (s[i]) return 4'b0000;
            if (p[i] && !m[i]) return {1'b1, 3'(i)};
        end
        return 4'b0000;
    endfunction

    function automatic logic [7:0] exp_rdata(input logic a);
        if (a) return m_mask;
        return m_svc_sel ? m_isr : m_irr;
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%02h expected=%02h at cycle %0d", req, act, exp, cycles);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    // Compare every output with the model.
    task automatic compare_all();
        logic [3:0] pr;
        pr = present(m_irr, m_isr, m_mask);
        chk({tag, " irq"}, {7'd0, cpu_irq}, {7'd0, pr[3]});
        if (pr[3]) chk({tag, " vec"}, vec_out, m_base + {5'd0, pr[2:0]});
        chk({tag, " rdata"}, bus_rdata, exp_rdata(bus_addr));
    endtask

    // One clock with the inputs set now; the model advances with the design.
    task automatic cyc();
        logic [3:0] pr;
        logic [7:0] edg, grant, clr, nirr, nisr;
        pr    = present(m_irr, m_isr, m_mask);
        edg   = irq_lines & ~m_prev & ~m_mask;
        grant = (cpu_ack && pr[3]) ? (8'h01 << pr[2:0]) : 8'h00;
        nirr  = (m_irr & ~grant) | edg;
        clr   = 8'h00;
        if (bus_wr && !bus_addr && bus_wdata[4:3] == 2'b00) begin
            if (bus_wdata[7:5] == 3'b001) clr = m_isr & (~m_isr + 8'h01);
            if (bus_wdata[7:5] == 3'b011) clr = 8'h01 << bus_wdata[2:0];
        end
        nisr = (m_isr & ~clr) | grant;
        if (bus_wr && !bus_addr) begin
            if (bus_wdata[4]) m_seq = 2'd1;
            else if (!bus_wdata[7] && bus_wdata[4:3] == 2'b01 && bus_wdata[1])
                m_svc_sel = bus_wdata[0];
        end else if (bus_wr && bus_addr) begin
            case (m_seq)
                2'd1: begin m_base = bus_wdata & 8'hF8; m_seq = 2'd2; end
                2'd2: m_seq = 2'd0;
                default: m_mask = bus_wdata;
            endcase
        end
        m_prev = irq_lines;
        @(posedge clk);
        m_irr = nirr;
        m_isr = nisr;
        @(negedge clk);
        compare_all();
        bus_wr  = 1'b0;
        cpu_ack = 1'b0;
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        bus_addr  = a;
        bus_wr    = 1'b1;
        bus_wdata = d;
        cyc();
    endtask

    task automatic rd(input string req, input logic a, input logic [7:0] exp);
        bus_addr = a;
        #1;
        chk(req, bus_rdata, exp);
    endtask

    // Watchdog: a hung run is a failure and still reports.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_fail++;
            $display("FAIL watchdog (all requirements) actual=%0d expected<150000", cycles);
            summary();
        end
    end

    initial begin
        void'($urandom(32'd7341));
        m_irr = 0; m_isr = 0; m_mask = 0; m_base = 0; m_prev = 8'hFF;
        m_seq = 0; m_svc_sel = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state.
        tag = "R1";
        chk("R1 irq after reset", {7'd0, cpu_irq}, 8'h00);
        rd("R1 pending readback", 1'b0, 8'h00);
        rd("R1 mask readback", 1'b1, 8'h00);

        // R7: init sequence, base byte low bits dropped, mask untouched.
        tag = "R7";
        wr(1'b0, 8'h13);
        wr(1'b1, 8'h47);
        rd("R7 mask kept during init", 1'b1, 8'h00);
        wr(1'b1, 8'h01);
        rd("R7 mask kept after mode byte", 1'b1, 8'h00);

        // R8: mask load and readback.
        tag = "R8";
        wr(1'b1, 8'h04);
        rd("R8 mask readback", 1'b1, 8'h04);

        // R3: masked pulse dropped, not revived by unmasking.
        tag = "R3";
        irq_lines = 8'h04; cyc();
        wr(1'b1, 8'h00);
        irq_lines = 8'h00; cyc();
        rd("R3 masked edge not latched", 1'b0, 8'h00);
        chk("R3 no irq", {7'd0, cpu_irq}, 8'h00);

        // R4 / R6: two lines, lowest wins, vector base+3.
        tag = "R4";
        irq_lines = 8'h28; cyc();
        chk("R4 irq raised", {7'd0, cpu_irq}, 8'h01);
        chk("R6 vector base plus 3", vec_out, 8'h43);
        tag = "R6";
        cpu_ack = 1'b1; cyc();
        // R5: line 3 in service blocks line 5.
        chk("R5 blocked by service", {7'd0, cpu_irq}, 8'h00);
        tag = "R11";
        wr(1'b0, 8'h0B);
        rd("R6 in-service after ack", 1'b0, 8'h08);
        wr(1'b0, 8'h0A);
        // R2: line 3 still high, not latched again.
        rd("R2 held line counted once", 1'b0, 8'h20);

        // R9 / R13: non-specific EOI, pending line 5 reappears.
        tag = "R9";
        wr(1'b0, 8'h20);
        chk("R13 re-presented after EOI", {7'd0, cpu_irq}, 8'h01);
        chk("R13 vector base plus 5", vec_out, 8'h45);
        cpu_ack = 1'b1; cyc();

        // R10: other OCW2 code ignored, specific EOI clears bit 5.
        tag = "R10";
        wr(1'b0, 8'h0B);
        wr(1'b0, 8'h40);
        rd("R10 other code no effect", 1'b0, 8'h20);
        tag = "R11";
        wr(1'b0, 8'h08);
        rd("R11 low bits 00 keep selection", 1'b0, 8'h20);
        tag = "R10";
        wr(1'b0, 8'h65);
        rd("R10 specific EOI cleared bit 5", 1'b0, 8'h00);
        irq_lines = 8'h00; cyc();

        // R12: new edge and acknowledge on the same line together.
        tag = "R12";
        wr(1'b0, 8'h0A);
        irq_lines = 8'h02; cyc();
        chk("R12 vector base plus 1", vec_out, 8'h41);
        irq_lines = 8'h00; cyc();
        irq_lines = 8'h02; cpu_ack = 1'b1; cyc();
        rd("R12 edge beats ack clear", 1'b0, 8'h02);
        chk("R12 blocked while in service", {7'd0, cpu_irq}, 8'h00);
        tag = "R13";
        wr(1'b0, 8'h20);
        chk("R13 pending line returns", {7'd0, cpu_irq}, 8'h01);
        cpu_ack = 1'b1; cyc();
        wr(1'b0, 8'h20);
        irq_lines = 8'h00; cyc();

        // Random phase: legal command patterns only (R2-R11 covered by model).
        tag = "R4 random";
        for (int n = 0; n < 4000; n++) begin
            logic [31:0] r;
            r = $urandom;
            if (r[3:0] == 4'd0) irq_lines = irq_lines ^ (8'h01 << r[6:4]);
            if (r[3:0] == 4'd1) irq_lines = 8'h00;
            if (r[9:7] == 3'd0 && cpu_irq) cpu_ack = 1'b1;
            bus_addr = r[10];
            if (m_seq == 2'd1) begin
                bus_addr = 1'b1; bus_wr = 1'b1; bus_wdata = r[31:24];
            end else if (m_seq == 2'd2) begin
                bus_addr = 1'b1; bus_wr = 1'b1; bus_wdata = 8'h01;
            end else if (r[13:11] == 3'd0) begin
                bus_wr = 1'b1;
                case (r[17:14])
                    4'd0, 4'd1, 4'd2: begin bus_addr = 1'b0; bus_wdata = 8'h20; end
                    4'd3, 4'd4:       begin bus_addr = 1'b0; bus_wdata = {5'b01100, r[20:18]}; end
                    4'd5:             begin bus_addr = 1'b0; bus_wdata = {r[23:21], 2'b00, r[20:18]}; end
                    4'd6, 4'd7:       begin bus_addr = 1'b0; bus_wdata = {6'b000010, r[19:18]}; end
                    4'd8:             begin bus_addr = 1'b0; bus_wdata = 8'h13; end
                    default:          begin bus_addr = 1'b1; bus_wdata = r[31:24] & r[23:16]; end
                endcase
            end
            cyc();
        end
        summary();
    end
endmodule